// File: doc/BRIEF.md
# Pixel Depth Expansion Pipeline

This block takes a stream of 16-bit pixels and turns each one into a 32-bit pixel. Input and output both use a valid/ready handshake. A one-bit format select arrives with every pixel and picks how that pixel is read.

- **Format select 0:** the input is a 5-6-5 red/green/blue word. The output is a byte-per-channel word whose top byte is zero.
- **Format select 1:** the input is a 4-4-4-4 word with alpha, red, green and blue. The output has a full byte for each of the four channels.

Each narrow channel grows to eight bits by repeating its most significant bits into the new low bits. This gives an exact full-scale mapping and needs no multiplier: all-ones in gives 0xFF out, and zero in gives 0x00 out.

There is one register stage between the handshakes. Under backpressure the stage holds its output word unchanged. No pixel is lost or repeated.

Top module: `pxw_expand`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With format select 0, input bits [15:11] are red, [10:5] are green and [4:0] are blue. The output places red in [23:16], green in [15:8] and blue in [7:0], and bits [31:24] are zero.
- R3: A 5-bit channel c becomes {c, c[4:2]}. For example, 5'b10101 gives 0xAD and 5'b00111 gives 0x39.
- R4: A 6-bit channel c becomes {c, c[5:4]}. For example, 6'b100001 gives 0x86.
- R5: With format select 1, the input nibbles [15:12], [11:8], [7:4] and [3:0] map to output bytes [31:24], [23:16], [15:8] and [7:0]. Each nibble n becomes {n, n}.
- R6: Full scale is exact. Input 0xFFFF gives 0x00FFFFFF with select 0 and 0xFFFFFFFF with select 1. Input 0x0000 gives 0 in both modes.
- R7: A pixel accepted at a clock edge shows on `out_valid`/`out_pixel` right after that edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_pixel` stays unchanged. Every accepted pixel is delivered exactly once, in order.
- R9: The format select is captured with each pixel, so changing it affects only pixels accepted afterwards.
- R10: `in_ready` is 1 exactly when the stage is empty or its output is being taken in the same cycle. A new pixel can therefore be accepted every cycle when `out_ready` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 1 | 0: 5-6-5 colour, 1: 4-4-4-4 with alpha; sampled with the pixel |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Stage can accept a pixel |
| in_pixel | input | 16 | Narrow pixel |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pixel | output | 32 | Wide pixel |

## Verification
Each pattern below tells a specific mistake apart:
- **Single-channel patterns** set one field to a sample such as 10101, 00111 or 100001. They show whether the low bits are filled by replication or by zeros, and whether a field landed in the wrong byte.
- **All-ones and all-zeros patterns** confirm that both ends of the scale are exact in both modes.
- **A distinct-nibble word** (0x1234) exposes any nibble-order swap in the alpha mode.
- **Streams that alternate the format select on every pixel, under pseudo-random backpressure,** show whether the select is captured per pixel. They also show whether a stalled word is held, dropped or sent twice.

// File: rtl/pxw_pkg.sv
package pxw_pkg;
  localparam int PIX_IN_W  = 16;
  localparam int PIX_OUT_W = 32;
  localparam int CH_OUT_W  = 8;

  typedef enum logic {
    FMT_RGB565   = 1'b0,
    FMT_ARGB4444 = 1'b1
  } pxw_fmt_e;

  // Map a narrow channel onto the 0..255 scale by repeating its top bits.
  function automatic logic [CH_OUT_W-1:0] widen_rep(input logic [CH_OUT_W-1:0] c,
                                                    input int unsigned w);
    logic [CH_OUT_W-1:0] r;
    for (int i = 0; i < CH_OUT_W; i++)
      r[CH_OUT_W-1-i] = c[w-1-(i % w)];
    return r;
  endfunction
endpackage

// File: rtl/pxw_chan_widen.sv
module pxw_chan_widen #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  narrow,
  output logic [OUT_W-1:0] wide
);
  // Output bit k (from the top) copies narrow bit (k mod IN_W) from the top.
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    assign wide[OUT_W-1-i] = narrow[IN_W-1-(i % IN_W)];
  end
endmodule

// File: rtl/pxw_format.sv
module pxw_format
  import pxw_pkg::*;
#(
  parameter int IN_W  = PIX_IN_W,
  parameter int OUT_W = PIX_OUT_W
) (
  input  pxw_fmt_e         fmt,
  input  logic [IN_W-1:0]  pix,
  output logic [OUT_W-1:0] wide
);
  localparam int NIB_W = IN_W / 4;
  localparam int BYTE_W = OUT_W / 4;

  logic [BYTE_W-1:0] red_w, grn_w, blu_w;
  logic [3:0][BYTE_W-1:0] nib_w;

  // 5-6-5 colour fields
  pxw_chan_widen #(.IN_W(5), .OUT_W(BYTE_W)) u_red (.narrow(pix[15:11]), .wide(red_w));
  pxw_chan_widen #(.IN_W(6), .OUT_W(BYTE_W)) u_grn (.narrow(pix[10:5]),  .wide(grn_w));
  pxw_chan_widen #(.IN_W(5), .OUT_W(BYTE_W)) u_blu (.narrow(pix[4:0]),   .wide(blu_w));

  // four equal nibble fields, same order in and out
  for (genvar k = 0; k < 4; k++) begin : g_nib
    pxw_chan_widen #(.IN_W(NIB_W), .OUT_W(BYTE_W)) u_nib (
      .narrow(pix[k*NIB_W +: NIB_W]),
      .wide  (nib_w[k])
    );
  end

  always_comb begin
    case (fmt)
      FMT_ARGB4444: wide = nib_w;
      default:      wide = {{BYTE_W{1'b0}}, red_w, grn_w, blu_w};
    endcase
  end
endmodule

// File: rtl/pxw_stage.sv
module pxw_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    out_data <= '0;
    else if (load) out_data <= in_data;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid); // R7
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R8
endmodule

// File: rtl/pxw_expand.sv
module pxw_expand
  import pxw_pkg::*;
#(
  parameter int IN_W  = PIX_IN_W,
  parameter int OUT_W = PIX_OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_pixel
);
  localparam int BYTE_W = OUT_W / 4;

  pxw_fmt_e         fmt;
  logic [OUT_W-1:0] wide_comb;
  logic             accept;

  assign fmt    = pxw_fmt_e'(fmt_sel);
  assign accept = in_valid && in_ready;

  // Conversion ahead of the register: the select travels with its pixel.
  pxw_format #(.IN_W(IN_W), .OUT_W(OUT_W)) u_format (
    .fmt  (fmt),
    .pix  (in_pixel),
    .wide (wide_comb)
  );

  pxw_stage #(.W(OUT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (wide_comb),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_pixel)
  );

  AST_RGB_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !fmt_sel |=> out_pixel[OUT_W-1 -: BYTE_W] == '0); // R2
  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fmt_sel && (&in_pixel) |=> (&out_pixel)); // R6
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R1
endmodule

// File: tb/pxw_expand_bench.sv
module pxw_expand_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_pixel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pixel;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          bp_en = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  bit          done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  pxw_expand u_pxw_expand (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_pixel(in_pixel), .out_valid(out_valid),
    .out_ready(out_ready), .out_pixel(out_pixel)
  );

  function automatic logic [31:0] model(input bit m, input logic [15:0] p);
    logic [7:0] r, g, b;
    if (m) begin
      return {8'(p[15:12]) * 8'd17, 8'(p[11:8]) * 8'd17,
              8'(p[7:4]) * 8'd17, 8'(p[3:0]) * 8'd17};
    end
    r = 8'(p[15:11]); g = 8'(p[10:5]); b = 8'(p[4:0]);
    return {8'h00, (r << 3) | (r >> 2), (g << 2) | (g >> 4), (b << 3) | (b >> 2)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic pick_ready();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  endtask

  task automatic send(input bit m, input logic [15:0] p, input string req);
    bit fired;
    do begin
      @(negedge clk);
      pick_ready();
      fmt_sel = m; in_pixel = p; in_valid = 1'b1;
      #1;
      fired = in_ready;
      if (fired) begin
        exp_q.push_back(model(m, p));
        tag_q.push_back(req);
      end
    end while (!fired);
    @(posedge clk);
    #0.5 in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pick_ready();
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    bit          prev_stall = 1'b0;
    logic [31:0] prev_pix = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (prev_stall)
          check(out_valid && out_pixel == prev_pix, "R8 hold", out_pixel, prev_pix);
        if (out_valid && !out_ready)
          check(!in_ready, "R10 full-stall ready", 32'(in_ready), 32'd0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 duplicate", out_pixel, 32'hxxxxxxxx);
          end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_pixel === e, t, out_pixel, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_pix   = out_pixel;
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1 reset", {30'd0, out_valid, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after reset", {30'd0, out_valid, in_ready}, 32'd1);

    // R7: latency of one edge
    send(1'b0, 16'h0000, "R6 zero rgb");
    @(negedge clk); #1;
    check(out_valid && out_pixel == 32'h0, "R7 latency", out_pixel, 32'h0);
    idle(2);

    send(1'b0, 16'hFFFF, "R6 full rgb");
    send(1'b0, 16'hA800, "R3 red 10101");
    send(1'b0, 16'h0007, "R3 blue 00111");
    send(1'b0, 16'h0420, "R4 green 100001");
    send(1'b0, 16'h001F, "R2 blue field");
    send(1'b0, 16'hF800, "R2 red field");
    send(1'b1, 16'hFFFF, "R6 full argb");
    send(1'b1, 16'h0000, "R6 zero argb");
    send(1'b1, 16'h1234, "R5 nibble order");
    send(1'b1, 16'hA5C3, "R5 mixed");
    idle(3);

    // R9 + R8: alternating select under backpressure
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++)
      send(i[0], 16'(i * 16'h3B1D + 16'h0F0F), "R9 per-pixel select");
    idle(10);
    bp_en = 1'b0;
    idle(5);
    check(exp_q.size() == 0, "R8 no drop", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule